// File: doc/BRIEF.md
# I2C Serial Memory Slave Engine

This block is the slave side of a two-wire serial memory holding up to 131,072 bytes. It sees the bus through SCL and SDA samples taken by a fast system clock, and it finds Start and Stop conditions from those samples. A select byte opens each transfer. In that byte the type nibble must read `1010`, the next two bits must match the two strap inputs, and the last bit picks a read or a write. The block returns acknowledges and read data by pulling SDA low through an open-drain enable.

A write carries a three-byte word address, most significant byte first. The address may be followed by data bytes. Data goes into a one-page staging buffer and reaches the array only when a Stop follows an acknowledged data byte. The commit then opens a busy window, and during that window the block ignores its own select code. A read starts either at the address left by a preceding address-only write (a random read through a repeated Start), or at the address just after the last byte handled (a current-address read). It then continues byte by byte for as long as the master acknowledges.

The engine runs through these states: `ST_IDLE`, `ST_DEV`, `ST_DEV_ACK`, `ST_ADDR`, `ST_ADDR_ACK`, `ST_WDATA`, `ST_WDATA_ACK`, `ST_RDATA`, `ST_RACK` and `ST_IGNORE`. A Start takes any state to `ST_DEV`, and a Stop takes any state to `ST_IDLE`. The other transitions are these:

- `ST_DEV` goes to `ST_DEV_ACK` when the select byte matches, and to `ST_IGNORE` when it does not.
- `ST_DEV_ACK` goes to `ST_RDATA` for a read, or to `ST_ADDR` for a write.
- `ST_ADDR` and `ST_ADDR_ACK` alternate until the last address byte. After it, `ST_ADDR_ACK` goes to `ST_WDATA`.
- `ST_WDATA` and `ST_WDATA_ACK` alternate while data is accepted. A refused byte sends `ST_WDATA_ACK` to `ST_IGNORE`.
- `ST_RDATA` goes to `ST_RACK` after eight bits.
- `ST_RACK` returns to `ST_RDATA` on a master acknowledge, and goes to `ST_IGNORE` on a NoAck.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A select byte is acknowledged only if bits 7..4 equal `1010`, bit 3 equals `strap_i[1]`, bit 2 equals `strap_i[0]`, and no busy window is open. Bit 1 is a don't-care. On a mismatch, SDA stays released until the next Start.
- R2: Bit 0 of the select byte is the direction flag. A 1 starts a read and a 0 starts a write.
- R3: The slave pulls SDA low during the ninth clock after every select byte and every address byte it accepts. The word address is three bytes sent most significant first, and the low 17 bits are used.
- R4: While `wr_lock_i` is high, select and address bytes are still acknowledged, but data bytes are not acknowledged and the array stays unchanged.
- R5: A write accepts up to 128 data bytes. The address advances after each byte. Only address bits 6..0 count up, and they wrap inside the 128-byte page while the higher bits stay fixed.
- R6: Buffered data is written to the array only on a Stop that directly follows an acknowledged data byte. A Start or Stop in the middle of a byte abandons the transfer, and the data is lost.
- R7: A commit opens a busy window of `BUSY_CYC` clock cycles. During the window the select code gets no acknowledge. After the window, the select code is acknowledged again.
- R8: A write that carries only an address, followed by a repeated Start and a read select, returns the byte at that address.
- R9: During a read, each master acknowledge makes the slave send the byte at the next address. A NoAck makes the slave release SDA.
- R10: A read select with no address continues from the byte after the last one read or written.
- R11: After reset, SDA is released and every array byte reads `0xFF`.
- R12: The SDA enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level as seen on the wire |
| strap_i | input | 2 | Chip-enable straps compared with select bits 3 and 2 |
| wr_lock_i | input | 1 | High blocks writes to the array |
| sda_oe_o | output | 1 | High pulls SDA low (open drain) |

## Verification
A wrong state or bit count shows up at the ports within one byte. It appears as an acknowledge in the wrong bit slot, or a missing one, and the master sees it on its next ninth clock. A wrong address register or a bad commit stays hidden until a later read, which then returns data that differs from the behavioural memory model held in the bench. That is why every write is read back, including page-wrap neighbours and bytes left untouched. A busy counter that runs too long or too short shows up as a wrongly acknowledged or refused select byte, tested both inside the window and after it.

// File: rtl/eeprom_slave_pkg.sv
package eeprom_slave_pkg;

    // Engine states; order has no behavioural meaning.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } slv_state_e;

    // Fixed device type nibble in select bits 7..4.
    localparam logic [3:0] TYPE_ID = 4'b1010;

endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_q,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_m, scl_s, scl_p;
    logic sda_m, sda_s, sda_p;

    // Two-flop synchronisers plus one history stage per line.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_m <= 1'b1;
            scl_s <= 1'b1;
            scl_p <= 1'b1;
            sda_m <= 1'b1;
            sda_s <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_m <= scl_i;
            scl_s <= scl_m;
            scl_p <= scl_s;
            sda_m <= sda_i;
            sda_s <= sda_m;
            sda_p <= sda_s;
        end
    end

    assign scl_q     = scl_s;
    assign sda_q     = sda_s;
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    // Data moving while the clock stays high marks a bus condition.
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/eeprom_store.sv
module eeprom_store #(
    parameter int MEM_DEPTH  = 1024,
    parameter int PAGE_BYTES = 128,
    parameter int BUSY_CYC   = 600
) (
    input  logic                                              clk,
    input  logic                                              rst_n,
    input  logic                                              buf_clear,
    input  logic                                              buf_we,
    input  logic [$clog2(PAGE_BYTES)-1:0]                     buf_idx,
    input  logic [7:0]                                        buf_data,
    input  logic                                              commit_req,
    input  logic [$clog2(MEM_DEPTH)-$clog2(PAGE_BYTES)-1:0]   page_base,
    input  logic [$clog2(MEM_DEPTH)-1:0]                      rd_idx,
    output logic [7:0]                                        rd_data,
    output logic                                              busy
);

    localparam int IDX_W    = $clog2(MEM_DEPTH);
    localparam int PG_W     = $clog2(PAGE_BYTES);
    localparam int BASE_W   = IDX_W - PG_W;
    localparam int BUSY_LEN = (BUSY_CYC > PAGE_BYTES) ? BUSY_CYC : PAGE_BYTES;
    localparam int CNT_W    = $clog2(BUSY_LEN + 1);
    localparam logic [PG_W-1:0] LAST_SLOT = PG_W'(PAGE_BYTES - 1);

    logic [7:0]            mem  [MEM_DEPTH];
    logic [7:0]            pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pvld;
    logic [CNT_W-1:0]      busy_cnt;
    logic                  committing;
    logic [PG_W-1:0]       cidx;
    logic [BASE_W-1:0]     base_q;

    // Staging buffer data needs no reset: the valid bits guard it.
    always_ff @(posedge clk) begin
        if (buf_we) pbuf[buf_idx] <= buf_data;
    end

    // Array, valid bits and the serial commit, one slot per cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= 8'hFF;
            pvld       <= '0;
            busy_cnt   <= '0;
            committing <= 1'b0;
            cidx       <= '0;
            base_q     <= '0;
        end else begin
            if (commit_req) begin
                busy_cnt   <= CNT_W'(BUSY_LEN);
                committing <= 1'b1;
                cidx       <= '0;
                base_q     <= page_base;
            end else begin
                if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
                if (committing) begin
                    if (pvld[cidx]) mem[{base_q, cidx}] <= pbuf[cidx];
                    cidx <= cidx + 1'b1;
                    if (cidx == LAST_SLOT) begin
                        committing <= 1'b0;
                        pvld       <= '0;
                    end
                end
            end
            if (buf_clear)   pvld          <= '0;
            else if (buf_we) pvld[buf_idx] <= 1'b1;
        end
    end

    assign rd_data = mem[rd_idx];
    assign busy    = busy_cnt != '0;

    // R7
    no_fill_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !buf_we);

endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
    parameter int MEM_DEPTH  = 1024,
    parameter int ADDR_W     = 17,
    parameter int ADDR_BYTES = 3,
    parameter int PAGE_BYTES = 128,
    parameter int BUSY_CYC   = 600
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] strap_i,
    input  logic       wr_lock_i,
    output logic       sda_oe_o
);

    import eeprom_slave_pkg::*;

    localparam int IDX_W  = $clog2(MEM_DEPTH);
    localparam int PG_W   = $clog2(PAGE_BYTES);
    localparam int AIDX_W = $clog2(ADDR_BYTES + 1);
    localparam logic [AIDX_W-1:0] LAST_ABYTE = AIDX_W'(ADDR_BYTES - 1);

    logic scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;

    slv_state_e        state_q, state_d;
    logic [3:0]        cnt_q;
    logic [7:0]        sh_q, tx_q;
    logic              ack_q, rw_q, pend_q;
    logic [AIDX_W-1:0] aidx_q;
    logic [ADDR_W-1:0] asm_q, addr_q;

    logic       byte_done, sel_match, busy;
    logic       buf_we, buf_clear, commit_req;
    logic [7:0] rd_data;

    i2c_line_sampler u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_q     (scl_q),
        .sda_q     (sda_q),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    eeprom_store #(
        .MEM_DEPTH  (MEM_DEPTH),
        .PAGE_BYTES (PAGE_BYTES),
        .BUSY_CYC   (BUSY_CYC)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .buf_clear  (buf_clear),
        .buf_we     (buf_we),
        .buf_idx    (addr_q[PG_W-1:0]),
        .buf_data   (sh_q),
        .commit_req (commit_req),
        .page_base  (addr_q[IDX_W-1:PG_W]),
        .rd_idx     (addr_q[IDX_W-1:0]),
        .rd_data    (rd_data),
        .busy       (busy)
    );

    assign byte_done = scl_fall && (cnt_q == 4'd8);
    assign sel_match = (sh_q[7:4] == TYPE_ID) && (sh_q[3:2] == strap_i) && !busy;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_DEV;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_DEV:       if (byte_done) state_d = sel_match ? ST_DEV_ACK : ST_IGNORE;
                ST_DEV_ACK:   if (scl_fall)  state_d = rw_q ? ST_RDATA : ST_ADDR;
                ST_ADDR:      if (byte_done) state_d = ST_ADDR_ACK;
                ST_ADDR_ACK:  if (scl_fall)  state_d = (aidx_q == LAST_ABYTE) ? ST_WDATA : ST_ADDR;
                ST_WDATA:     if (byte_done) state_d = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall)  state_d = ack_q ? ST_WDATA : ST_IGNORE;
                ST_RDATA:     if (scl_fall && cnt_q == 4'd7) state_d = ST_RACK;
                ST_RACK:      if (scl_fall)  state_d = ack_q ? ST_RDATA : ST_IGNORE;
                ST_IGNORE:    state_d = ST_IGNORE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // Datapath: shift registers, counters, address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sh_q   <= '0;
            tx_q   <= 8'hFF;
            ack_q  <= 1'b0;
            rw_q   <= 1'b0;
            pend_q <= 1'b0;
            aidx_q <= '0;
            asm_q  <= '0;
            addr_q <= '0;
        end else if (start_det || stop_det) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_DEV, ST_ADDR, ST_WDATA: begin
                    if (scl_rise && cnt_q < 4'd8) begin
                        sh_q  <= {sh_q[6:0], sda_q};
                        cnt_q <= cnt_q + 1'b1;
                    end
                    if (byte_done) begin
                        cnt_q <= '0;
                        if (state_q == ST_DEV) begin
                            ack_q  <= sel_match;
                            rw_q   <= sh_q[0];
                            aidx_q <= '0;
                        end else if (state_q == ST_ADDR) begin
                            ack_q <= 1'b1;
                            asm_q <= {asm_q[ADDR_W-9:0], sh_q};
                        end else begin
                            ack_q <= !wr_lock_i;
                            if (!wr_lock_i) begin
                                // R5: only the in-page offset advances
                                addr_q <= {addr_q[ADDR_W-1:PG_W], addr_q[PG_W-1:0] + 1'b1};
                                pend_q <= 1'b1;
                            end
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall && rw_q) tx_q <= rd_data;
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (aidx_q == LAST_ABYTE) addr_q <= asm_q;
                        else                      aidx_q <= aidx_q + 1'b1;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (cnt_q == 4'd7) begin
                            cnt_q  <= '0;
                            addr_q <= addr_q + 1'b1;
                        end else begin
                            tx_q  <= {tx_q[6:0], 1'b1};
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) ack_q <= !sda_q;
                    if (scl_fall && ack_q) tx_q <= rd_data;
                end
                default: ;
            endcase
        end
    end

    // Outputs: SDA enable and store controls
    always_comb begin
        unique case (state_q)
            ST_DEV_ACK, ST_ADDR_ACK, ST_WDATA_ACK: sda_oe_o = ack_q;
            ST_RDATA:                              sda_oe_o = !tx_q[7];
            default:                               sda_oe_o = 1'b0;
        endcase
        buf_we     = (state_q == ST_WDATA) && byte_done && !wr_lock_i && !start_det && !stop_det;
        buf_clear  = (state_q == ST_ADDR_ACK) && scl_fall && (aidx_q == LAST_ABYTE) && !start_det && !stop_det;
        // R6: commit only right after an acknowledged data byte
        commit_req = stop_det && (state_q == ST_WDATA) && (cnt_q <= 4'd1) && pend_q;
    end

    // R12
    oe_quiet_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_q);

    // R4
    lock_no_data_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WDATA_ACK && wr_lock_i) |-> !sda_oe_o);

    // R1
    sel_ack_needs_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEV_ACK && sda_oe_o) |-> (sh_q[7:4] == TYPE_ID));

    // R5
    page_high_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WDATA_ACK && $past(state_q) == ST_WDATA)
            |-> addr_q[ADDR_W-1:PG_W] == $past(addr_q[ADDR_W-1:PG_W]));

endmodule

// File: tb/test_i2c_eeprom_slave.sv
module test_i2c_eeprom_slave;

    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 8;
    localparam int MEM_DEPTH  = 1024;
    localparam int SETTLE     = 700;
    localparam logic [1:0] STRAP = 2'b10;

    typedef logic [7:0] byte_q_t[$];

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic wr_lock = 1'b0;
    logic sda_oe;
    logic bus_sda;

    int total = 0;
    int bad = 0;
    int oe_glitch = 0;
    bit finished = 1'b0;
    int ptr = 0;
    logic [7:0] ref_mem [MEM_DEPTH];
    logic prev_oe = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign bus_sda = m_sda && !sda_oe;

    i2c_eeprom_slave i_i2c_eeprom_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (m_scl),
        .sda_i     (bus_sda),
        .strap_i   (STRAP),
        .wr_lock_i (wr_lock),
        .sda_oe_o  (sda_oe)
    );

    // Per-clock monitor: R12, enable may move only while SCL is low
    always @(negedge clk) begin
        if (rst_n && sda_oe !== prev_oe && m_scl) oe_glitch++;
        prev_oe <= sda_oe;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic qw();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; qw();
        m_scl = 1'b1; qw();
        m_sda = 1'b0; qw();
        m_scl = 1'b0; qw();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; qw();
        m_scl = 1'b1; qw();
        m_sda = 1'b1; qw();
    endtask

    task automatic send_bit(input logic v);
        m_sda = v; qw();
        m_scl = 1'b1; qw(); qw();
        m_scl = 1'b0; qw();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ackd);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_sda = 1'b1; qw();
        m_scl = 1'b1; qw();
        ackd = !bus_sda; qw();
        m_scl = 1'b0; qw();
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit mack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; qw();
            m_scl = 1'b1; qw();
            b[i] = bus_sda; qw();
            m_scl = 1'b0; qw();
        end
        m_sda = mack ? 1'b0 : 1'b1; qw();
        m_scl = 1'b1; qw(); qw();
        m_scl = 1'b0; qw();
        m_sda = 1'b1;
    endtask

    function automatic logic [7:0] sel(input logic rw);
        return {4'b1010, STRAP, 1'b0, rw};
    endfunction

    task automatic send_addr(input int a, input string tag);
        logic k;
        send_byte(8'(a >> 16), k); chk(k, tag, k, 1);
        send_byte(8'(a >> 8), k);  chk(k, tag, k, 1);
        send_byte(8'(a), k);       chk(k, tag, k, 1);
    endtask

    // Page write with reference update; settle waits out the busy window
    task automatic wr_txn(input int a, input byte_q_t d, input bit lock, input bit settle);
        logic k;
        int pa;
        wr_lock = lock;
        bus_start();
        send_byte(sel(1'b0), k); chk(k, "R3 select ack", k, 1);
        send_addr(a, "R3 address ack");
        foreach (d[i]) begin
            send_byte(d[i], k);
            if (lock) chk(!k, "R4 data nack under lock", k, 0);
            else      chk(k, "R3 data ack", k, 1);
            if (!lock) begin
                pa = (a & ~127) | ((a + i) & 127);
                ref_mem[pa % MEM_DEPTH] = d[i];
            end
        end
        bus_stop();
        ptr = lock ? a : ((a & ~127) | ((a + d.size()) & 127));
        wr_lock = 1'b0;
        if (settle) repeat (SETTLE) @(negedge clk);
    endtask

    task automatic rd_rand(input int a, input int n, input string tag);
        logic k;
        logic [7:0] b;
        bus_start();
        send_byte(sel(1'b0), k); chk(k, tag, k, 1);
        send_addr(a, tag);
        bus_start();
        send_byte(sel(1'b1), k); chk(k, tag, k, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(b, i != n - 1);
            chk(b == ref_mem[(a + i) % MEM_DEPTH], tag, b, ref_mem[(a + i) % MEM_DEPTH]);
        end
        bus_stop();
        ptr = a + n;
    endtask

    task automatic rd_cur(input int n, input string tag);
        logic k;
        logic [7:0] b;
        bus_start();
        send_byte(sel(1'b1), k); chk(k, tag, k, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(b, i != n - 1);
            chk(b == ref_mem[(ptr + i) % MEM_DEPTH], tag, b, ref_mem[(ptr + i) % MEM_DEPTH]);
        end
        bus_stop();
        ptr = ptr + n;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic k;
        logic [7:0] b;
        for (int i = 0; i < MEM_DEPTH; i++) ref_mem[i] = 8'hFF;
        repeat (5) @(negedge clk);
        // R11: enable released during and right after reset
        chk(sda_oe == 1'b0, "R11 reset release", sda_oe, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(sda_oe == 1'b0, "R11 idle release", sda_oe, 0);

        // R11 erased content, R8 random read
        rd_rand(5, 2, "R11 erased read");

        // R3 single byte write, R8 read back
        wr_txn(16, '{8'h3C}, 1'b0, 1'b1);
        rd_rand(16, 1, "R8 random read");

        // R5 multi-byte page write, R9 sequential read
        wr_txn(32, '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55}, 1'b0, 1'b1);
        rd_rand(32, 5, "R9 sequential read");

        // R10 current address continues after last read byte
        rd_rand(33, 1, "R10 setup");
        rd_cur(2, "R10 current address read");

        // R5 wrap inside page: 126,127 then 0,1 of same page
        wr_txn(126, '{8'hA1, 8'hA2, 8'hA3, 8'hA4}, 1'b0, 1'b1);
        rd_rand(126, 4, "R5 wrap neighbours");
        rd_rand(0, 2, "R5 wrapped bytes");

        // R4 write lock: select and address acked, data refused
        wr_txn(16, '{8'h99, 8'h98}, 1'b1, 1'b1);
        rd_rand(16, 2, "R4 array unchanged");

        // R1 wrong type nibble: no ack, silent for the byte after
        bus_start();
        send_byte(8'b1011_1001, k); chk(!k, "R1 wrong type nack", k, 0);
        recv_byte(b, 1'b0); chk(b == 8'hFF, "R1 silent after mismatch", b, 8'hFF);
        bus_stop();
        // R1 wrong strap
        bus_start();
        send_byte({4'b1010, ~STRAP, 2'b01}, k); chk(!k, "R1 wrong strap nack", k, 0);
        bus_stop();
        // R1 bit 1 is a don't-care, R2 write direction
        bus_start();
        send_byte({4'b1010, STRAP, 2'b10}, k); chk(k, "R1 bit1 ignored", k, 1);
        bus_stop();

        // R7 busy window refuses select, then reopens
        wr_txn(64, '{8'h5A}, 1'b0, 1'b0);
        bus_start();
        send_byte(sel(1'b0), k); chk(!k, "R7 nack while busy", k, 0);
        bus_stop();
        repeat (SETTLE) @(negedge clk);
        bus_start();
        send_byte(sel(1'b0), k); chk(k, "R7 ack after window", k, 1);
        bus_stop();
        rd_rand(64, 1, "R7 committed byte");

        // R6 stop in mid-byte abandons buffered data and opens no window
        bus_start();
        send_byte(sel(1'b0), k); chk(k, "R6 select", k, 1);
        send_addr(72, "R6 address");
        send_byte(8'h77, k); chk(k, "R6 data ack", k, 1);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_stop();
        bus_start();
        send_byte(sel(1'b0), k); chk(k, "R6 no busy after abort", k, 1);
        bus_stop();
        rd_rand(72, 1, "R6 nothing stored");

        // R6 start in mid-byte abandons buffered data
        bus_start();
        send_byte(sel(1'b0), k);
        send_addr(80, "R6 address");
        send_byte(8'h66, k); chk(k, "R6 data ack", k, 1);
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        bus_start();
        send_byte(sel(1'b0), k); chk(k, "R6 restart ack", k, 1);
        bus_stop();
        rd_rand(80, 1, "R6 nothing stored after restart");

        // R3 full three-byte address above the first 64 kbytes
        wr_txn(32'h1_0300, '{8'hC7, 8'hC8}, 1'b0, 1'b1);
        rd_rand(32'h1_0300, 2, "R3 high address");

        chk(oe_glitch == 0, "R12 enable moved with SCL high", oe_glitch, 0);
        finish_run();
    end

endmodule